// File: doc/BRIEF.md
# Dual-Tone Keypad Sine Synthesizer

This block turns a 4-bit keypad code into a burst of dual-tone samples for a simple 6-bit ladder converter. Each key picks one of four low-band tones (697, 770, 852, 941 Hz) and one of four high-band tones (1209, 1336, 1477, 1633 Hz). Every tone is stored as a short constant table that holds a whole number of sine cycles. Each table has its own length, and all of them are stepped at one common update rate. On each update, the block adds one entry from the selected low table to one entry from the selected high table and registers the sum as the output sample.

A pulse on `start` latches the key and clears both table pointers, and the burst begins. From then on, every `TICKS_PER_SAMPLE` enabled ticks of `tick_en` produce a new sample. The burst lasts the nominal tone time plus one update interval, because the first sample only appears after one full interval. The high band sits on a higher baseline with a larger swing, which gives the pre-emphasis toward the high group. Outside a burst the output rests at the combined baseline.

Top module: `dtmf_synth`

## Requirements
- R1: After reset, and at all times outside a burst, `active` is 0 and `sample` is 29.
- R2: A rising `start` latches `key`. Bits [3:2] select the low tone: 0=697, 1=770, 2=852, 3=941 Hz. Bits [1:0] select the high tone: 0=1209, 1=1336, 2=1477, 3=1633 Hz. Changes on `key` during a burst have no effect on the samples.
- R3: Only cycles with `tick_en` high count. `sample` changes only on the enabled tick that completes each group of `TICKS_PER_SAMPLE` ticks, and it holds its value in between.
- R4: The first sample of a burst is registered on the `TICKS_PER_SAMPLE`-th enabled tick after `start`. It is built from entry 0 of both tables.
- R5: The 697 Hz table has 49 entries spanning 4 cycles, and the 770 Hz table has 11 entries spanning 1 cycle. Entry k is 13 + round(13·sin(2π·c·k/N)).
- R6: The 852 Hz table is 13 plus {0,8,12,13,8,0,−8,−12,−13,−8}. The 941 Hz table is 13 plus {0,8,13,11,5,−5,−11,−13,−8}.
- R7: The high tables (1209: 7 entries/1 cycle, 1336: 19/3, 1477: 23/4, 1633: 21/4) hold 16 + round(16·sin(2π·c·k/N)).
- R8: Each sample uses both pointers before they advance. A pointer whose incremented value equals its table length returns to 0.
- R9: A burst lasts exactly TONE_TICKS + TICKS_PER_SAMPLE enabled ticks. On the last of these ticks `active` falls and `sample` returns to 29. If a sample update falls on that same tick, the end of the burst takes precedence.
- R10: A `start` during a burst restarts it: the new key is latched, both pointers and the timing restart, and `sample` goes to 29.
- R11: `sample` never exceeds 58.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Tick enable that paces the update interval |
| start | input | 1 | Begins (or restarts) a burst and latches the key |
| key | input | 4 | Key code: row in [3:2], column in [1:0] |
| sample | output | 6 | Summed low-band plus high-band level |
| active | output | 1 | High while a burst is being produced |

## Verification
The bench builds the block with an update interval of 3 ticks and a tone time of 330 ticks. With these values a burst spans 110 updates, so even the 49-entry table wraps twice, and every table returns to its start several times within each key's burst. Because 330 is a multiple of 3, the final tick of each burst also falls on an update tick, which exercises the end-over-update precedence. The short bursts also leave room for all sixteen keys, sparse tick patterns, a mid-burst key change and a restart.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int SAMPLE_W      = 6;
    localparam int LOW_BASE      = 13;
    localparam int HIGH_BASE     = 16;
    localparam int MID_LEVEL     = LOW_BASE + HIGH_BASE;
    localparam int PEAK_LEVEL    = 2 * MID_LEVEL;
    localparam int TONES_PER_BAND = 4;
    localparam int LOW_MAX_LEN   = 49;
    localparam int HIGH_MAX_LEN  = 23;

    // fixed-point scale for elaboration-time sine evaluation
    localparam longint FX_ONE     = 64'sd16777216;
    localparam longint FX_HALF_PI = 64'sd26353589;

    // number of entries stored for a tone
    function automatic int tone_len(input bit high, input int idx);
        int n;
        if (high) begin
            case (idx)
                0:       n = 7;
                1:       n = 19;
                2:       n = 23;
                default: n = 21;
            endcase
        end else begin
            case (idx)
                0:       n = 49;
                1:       n = 11;
                2:       n = 10;
                default: n = 9;
            endcase
        end
        return n;
    endfunction

    // whole sine cycles held across the tone's table
    function automatic int tone_cycles(input bit high, input int idx);
        int c;
        if (high) begin
            case (idx)
                0:       c = 1;
                1:       c = 3;
                default: c = 4;
            endcase
        end else begin
            c = (idx == 0) ? 4 : 1;
        end
        return c;
    endfunction

    // round(amp * sin(2*pi*num/den)), computed with integers only
    function automatic int round_sine(input int amp, input int num, input int den);
        longint d;
        longint u;
        longint theta;
        longint x2;
        longint term;
        longint acc;
        longint mag;
        bit     neg;
        d   = longint'(den);
        u   = longint'(num % den) * 64'sd4;
        neg = 1'b0;
        if (u >= 2 * d) begin
            u   = u - 2 * d;
            neg = 1'b1;
        end
        if (u > d) u = 2 * d - u;
        theta = (FX_HALF_PI * u) / d;
        x2    = (theta * theta) / FX_ONE;
        term  = theta;
        acc   = theta;
        for (int n = 1; n <= 6; n++) begin
            term = -((term * x2) / FX_ONE) / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        if (acc < 0) acc = 0;
        mag = (acc * longint'(amp) + FX_ONE / 2) / FX_ONE;
        return neg ? -int'(mag) : int'(mag);
    endfunction

    // stored level for entry k of a tone; two low tones use area-corrected values
    function automatic int tone_entry(input bit high, input int idx, input int k);
        int off;
        int base;
        base = high ? HIGH_BASE : LOW_BASE;
        if (!high && idx == 2) begin
            case (k)
                1, 4:    off = 8;
                2:       off = 12;
                3:       off = 13;
                6, 9:    off = -8;
                7:       off = -12;
                8:       off = -13;
                default: off = 0;
            endcase
        end else if (!high && idx == 3) begin
            case (k)
                1:       off = 8;
                2:       off = 13;
                3:       off = 11;
                4:       off = 5;
                5:       off = -5;
                6:       off = -11;
                7:       off = -13;
                8:       off = -8;
                default: off = 0;
            endcase
        end else begin
            off = round_sine(base, tone_cycles(high, idx) * k, tone_len(high, idx));
        end
        return base + off;
    endfunction

endpackage

// File: rtl/dtmf_pacer.sv
module dtmf_pacer #(
    parameter int TICKS_PER_SAMPLE = 42,
    parameter int TONE_TICKS       = 35796
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic active_o,
    output logic step_o,
    output logic done_o
);
    localparam int BURST_TICKS = TONE_TICKS + TICKS_PER_SAMPLE;
    localparam int DIV_W       = $clog2(TICKS_PER_SAMPLE + 1);
    localparam int BURST_W     = $clog2(BURST_TICKS + 1);
    localparam logic [DIV_W-1:0]   DIV_LAST   = DIV_W'(TICKS_PER_SAMPLE - 1);
    localparam logic [BURST_W-1:0] BURST_LAST = BURST_W'(BURST_TICKS - 1);

    typedef struct packed {
        logic               active;
        logic [DIV_W-1:0]   div;
        logic [BURST_W-1:0] burst;
    } pacer_t;

    pacer_t cur_q, nxt_d;
    logic   step_d;
    logic   done_d;

    always_comb begin
        nxt_d  = cur_q;
        step_d = 1'b0;
        done_d = 1'b0;
        if (start_i) begin
            nxt_d.active = 1'b1;
            nxt_d.div    = '0;
            nxt_d.burst  = '0;
        end else if (cur_q.active && tick_i) begin
            if (cur_q.burst == BURST_LAST) begin
                nxt_d.active = 1'b0;
                done_d       = 1'b1;
            end else begin
                nxt_d.burst = cur_q.burst + BURST_W'(1);
                if (cur_q.div == DIV_LAST) begin
                    nxt_d.div = '0;
                    step_d    = 1'b1;
                end else begin
                    nxt_d.div = cur_q.div + DIV_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign active_o = cur_q.active;
    assign step_o   = step_d;
    assign done_o   = done_d;

    // R3
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.div <= DIV_LAST);

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !start_i) |=> $stable(cur_q));

    // R9
    done_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !active_o);

    // R9
    step_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_o && done_o));

endmodule

// File: rtl/dtmf_band.sv
module dtmf_band
    import dtmf_pkg::*;
#(
    parameter bit HIGH_BAND = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic [1:0]          tone_i,
    output logic [SAMPLE_W-1:0] level_o
);
    localparam int MAX_LEN = HIGH_BAND ? HIGH_MAX_LEN : LOW_MAX_LEN;
    localparam int PTR_W   = $clog2(MAX_LEN + 1);
    localparam int BASE    = HIGH_BAND ? HIGH_BASE : LOW_BASE;

    typedef struct packed {
        logic [1:0]       tone;
        logic [PTR_W-1:0] ptr;
    } band_t;

    band_t               cur_q, nxt_d;
    logic [SAMPLE_W-1:0] rom     [TONES_PER_BAND][MAX_LEN];
    logic [PTR_W-1:0]    len_tbl [TONES_PER_BAND];
    logic [PTR_W-1:0]    ptr_inc;

    for (genvar t = 0; t < TONES_PER_BAND; t++) begin : g_tone
        localparam int LEN = tone_len(HIGH_BAND, t);
        assign len_tbl[t] = PTR_W'(LEN);
        for (genvar k = 0; k < MAX_LEN; k++) begin : g_entry
            if (k < LEN) begin : g_used
                assign rom[t][k] = SAMPLE_W'(tone_entry(HIGH_BAND, t, k));
            end else begin : g_pad
                assign rom[t][k] = '0;
            end
        end
    end

    always_comb begin
        nxt_d   = cur_q;
        ptr_inc = cur_q.ptr + PTR_W'(1);
        if (load_i) begin
            nxt_d.tone = tone_i;
            nxt_d.ptr  = '0;
        end else if (step_i) begin
            nxt_d.ptr = (ptr_inc == len_tbl[cur_q.tone]) ? '0 : ptr_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign level_o = rom[cur_q.tone][cur_q.ptr];

    // R8
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.ptr < len_tbl[cur_q.tone]);

    // R8
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && (cur_q.ptr == len_tbl[cur_q.tone] - PTR_W'(1)))
        |=> (cur_q.ptr == '0));

    // R2
    tone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cur_q.tone));

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= SAMPLE_W'(2 * BASE));

endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
    import dtmf_pkg::*;
#(
    parameter int TICKS_PER_SAMPLE = 42,
    parameter int TONE_TICKS       = 35796
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                start,
    input  logic [3:0]          key,
    output logic [SAMPLE_W-1:0] sample,
    output logic                active
);
    localparam logic [SAMPLE_W-1:0] REST = SAMPLE_W'(MID_LEVEL);

    typedef struct packed {
        logic [SAMPLE_W-1:0] level;
    } synth_t;

    synth_t              cur_q, nxt_d;
    logic                step;
    logic                done;
    logic [SAMPLE_W-1:0] low_lvl;
    logic [SAMPLE_W-1:0] high_lvl;
    logic [SAMPLE_W-1:0] mix;

    dtmf_pacer #(
        .TICKS_PER_SAMPLE (TICKS_PER_SAMPLE),
        .TONE_TICKS       (TONE_TICKS)
    ) i_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .tick_i   (tick_en),
        .active_o (active),
        .step_o   (step),
        .done_o   (done)
    );

    dtmf_band #(.HIGH_BAND(1'b0)) i_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .step_i  (step),
        .tone_i  (key[3:2]),
        .level_o (low_lvl)
    );

    dtmf_band #(.HIGH_BAND(1'b1)) i_high (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .step_i  (step),
        .tone_i  (key[1:0]),
        .level_o (high_lvl)
    );

    assign mix = low_lvl + high_lvl;

    always_comb begin
        nxt_d = cur_q;
        if (start || done) nxt_d.level = REST;
        else if (step)     nxt_d.level = mix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q.level <= REST;
        else        cur_q <= nxt_d;
    end

    assign sample = cur_q.level;

    // R11
    sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample <= SAMPLE_W'(PEAK_LEVEL));

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (sample == REST));

    // R3
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !start && !done) |=> $stable(sample));

    // R10
    restart_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && sample == REST));

endmodule

// File: tb/test_dtmf_synth.sv
module test_dtmf_synth;
    localparam int T     = 3;
    localparam int TONE  = 330;
    localparam int BURST = TONE + T;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       start = 1'b0;
    logic [3:0] key = 4'd0;
    logic [5:0] sample;
    logic       active;

    always #4 clk = ~clk;

    dtmf_synth #(.TICKS_PER_SAMPLE(T), .TONE_TICKS(TONE)) i_dtmf_synth (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .start   (start),
        .key     (key),
        .sample  (sample),
        .active  (active)
    );

    // expected tables, built from the sine formula and the corrected lists
    int lo_tab [4][$];
    int hi_tab [4][$];
    int lo_len [4] = '{49, 11, 10, 9};
    int lo_cyc [4] = '{4, 1, 1, 1};
    int hi_len [4] = '{7, 19, 23, 21};
    int hi_cyc [4] = '{1, 3, 4, 4};
    int fix852 [10] = '{0, 8, 12, 13, 8, 0, -8, -12, -13, -8};
    int fix941 [9]  = '{0, 8, 13, 11, 5, -5, -11, -13, -8};

    function automatic void build_tables();
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < lo_len[r]; k++) begin
                real a;
                a = 2.0 * 3.14159265358979 * lo_cyc[r] * k / lo_len[r];
                if (r == 2)      lo_tab[r].push_back(13 + fix852[k]);
                else if (r == 3) lo_tab[r].push_back(13 + fix941[k]);
                else             lo_tab[r].push_back(13 + int'(13.0 * $sin(a)));
            end
            for (int k = 0; k < hi_len[r]; k++) begin
                real a;
                a = 2.0 * 3.14159265358979 * hi_cyc[r] * k / hi_len[r];
                hi_tab[r].push_back(16 + int'(16.0 * $sin(a)));
            end
        end
    endfunction

    // reference model state
    bit    m_active = 1'b0;
    int    m_ticks = 0;
    int    m_samples = 0;
    int    m_row = 0;
    int    m_col = 0;
    int    m_sample = 29;
    bit    m_ran = 1'b0;
    int    vectors = 0;
    int    miscompares = 0;
    int    cyc = 0;
    bit    checking = 1'b0;
    string phase_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 1'b0;
            m_sample = 29;
        end else if (start) begin
            m_active  = 1'b1;
            m_ticks   = 0;
            m_samples = 0;
            m_row     = int'(key[3:2]);
            m_col     = int'(key[1:0]);
            m_sample  = 29;
            m_ran     = 1'b1;
        end else if (m_active && tick_en) begin
            m_ticks++;
            if (m_ticks == BURST) begin
                m_active = 1'b0;
                m_sample = 29;
            end else if (m_ticks % T == 0) begin
                m_sample = lo_tab[m_row][m_samples % lo_len[m_row]]
                         + hi_tab[m_col][m_samples % hi_len[m_col]];
                m_samples++;
            end
        end
    end

    function automatic string req_tag();
        if (!m_active) return m_ran ? "R9" : "R1";
        if (m_samples == 0) return "R4";
        return phase_tag;
    endfunction

    task automatic report_done();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (checking) begin
            vectors++;
            if ($isunknown(sample) || int'(sample) != m_sample || active !== m_active) begin
                miscompares++;
                $display("FAIL %s cycle %0d: sample=%0d active=%0b, expected sample=%0d active=%0b",
                         req_tag(), cyc, sample, active, m_sample, m_active);
            end
            vectors++;
            if (int'(sample) > 58) begin
                miscompares++;
                $display("FAIL R11 cycle %0d: sample=%0d, expected at most 58", cyc, sample);
            end
        end
        if (cyc > WATCHDOG) begin
            miscompares++;
            $display("FAIL R9 watchdog: run still going at cycle %0d, expected end before %0d", cyc, WATCHDOG);
            report_done();
        end
    end

    task automatic idle(input int n, input int density);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start   = 1'b0;
            tick_en = ($urandom_range(0, 99) < density);
        end
    endtask

    task automatic fire(input logic [3:0] k);
        @(negedge clk);
        key     = k;
        start   = 1'b1;
        tick_en = 1'b1;
    endtask

    task automatic finish_burst(input int density);
        do idle(1, density); while (m_active);
        idle(6, density);
    endtask

    initial begin
        build_tables();
        repeat (3) @(negedge clk);
        // R1: state held under reset
        vectors++;
        if (int'(sample) != 29 || active !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset: sample=%0d active=%0b, expected sample=29 active=0", sample, active);
        end
        rst_n    = 1'b1;
        checking = 1'b1;

        // R1: ticks without a start leave the output at rest
        idle(12, 100);

        // R5 R6 R7 R8: every key, full and partial tick density
        for (int k = 0; k < 16; k++) begin
            phase_tag = (k < 8) ? "R5/R7/R8" : "R6/R7/R8";
            fire(4'(k));
            finish_burst((k % 2 == 0) ? 100 : 70);
        end

        // R2: key input moves during the burst
        phase_tag = "R2";
        fire(4'h5);
        idle(40, 100);
        key = 4'hA;
        idle(30, 100);
        key = 4'h3;
        finish_burst(100);

        // R3: sparse enable
        phase_tag = "R3";
        fire(4'hF);
        finish_burst(25);

        // R10: restart mid-burst with another key
        phase_tag = "R10";
        fire(4'h3);
        idle(100, 100);
        phase_tag = "R10";
        fire(4'hC);
        finish_burst(100);

        report_done();
    end
endmodule